// File: doc/BRIEF.md
# Segmented Address Translator

This block turns a logical address made of a segment number and an offset into a physical address. The descriptor table sits in ordinary memory. A table-origin input gives its word address and a table-count input says how many segments exist. For each request the unit first checks the segment number against the count, without touching memory. It then fetches one descriptor word over a simple read port and runs the protection checks on it in a fixed order. It finishes with one completion pulse carrying the physical address, or one fault pulse carrying a two-bit cause.

A requester raises `req_valid` for one cycle while `busy` is low, then waits for `done` or `fault`. The memory answers each `mem_req` pulse with one `mem_rvalid` pulse that carries the descriptor word. The answer comes at least one cycle after the request, and any number of cycles later is allowed.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `busy`, `mem_req`, `done` and `fault` are all low.
- R2: If the segment number is not strictly less than `table_len`, the unit pulses `fault` for one cycle with `fault_code` 0 on the cycle after acceptance. It does not raise `mem_req` for that request.
- R3: For a legal segment number, `mem_req` pulses for exactly one cycle on the cycle after acceptance. `mem_addr` then equals `table_base` plus the segment number, modulo 2^MEM_AW, using the values present at acceptance.
- R4: The descriptor word is laid out as follows. Bits [PA_W-1:0] hold the base. The next LIM_W bits (LIM_W = OFF_W+1) hold the limit. The four bits above the limit are, from lowest to highest: valid, read-allowed, write-allowed and execute-allowed. With the defaults these are base [15:0], limit [28:16] and flag bits 29 to 32.
- R5: If the descriptor's valid bit is 0, the result is a fault with code 1. This takes precedence over the limit and permission checks.
- R6: If the offset is greater than or equal to the limit, the result is a fault with code 2. This takes precedence over the permission check.
- R7: `req_acc` encodes the access as 0 read, 1 write and 2 execute. If the matching allow bit is 0, the result is a fault with code 3. Encoding 3 always faults with code 3.
- R8: When all checks pass, `done` pulses for one cycle on the cycle after `mem_rvalid`. `phys_addr` equals base plus offset, modulo 2^PA_W.
- R9: Each accepted request yields exactly one one-cycle pulse of either `done` or `fault`, never both. While `busy` is high, `req_valid` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within the segment |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| table_base | input | MEM_AW | Word address of descriptor 0 |
| table_len | input | SEG_W+1 | Number of descriptors |
| busy | output | 1 | A request is in progress |
| mem_req | output | 1 | Descriptor read strobe |
| mem_addr | output | MEM_AW | Descriptor word address |
| mem_rvalid | input | 1 | Descriptor word is present |
| mem_rdata | input | PA_W+OFF_W+5 | Descriptor word |
| done | output | 1 | Translation succeeded |
| phys_addr | output | PA_W | Physical address, valid with done |
| fault | output | 1 | Translation failed |
| fault_code | output | 2 | Cause: 0 segment number, 1 invalid, 2 limit, 3 permission |

## Verification
The assertions watch properties that must hold on every cycle. `done` and `fault` are never high together. The read strobe never lasts longer than one cycle. A code-0 fault only ever follows an idle cycle, so no fetch took place. Every completion, and every fault that needed the descriptor, follows a busy cycle. Only the bench scenarios can show the values themselves: the fetched address, the sum for the physical address, the order in which the checks take precedence, the limit boundary at limit minus one against the limit itself, and requests dropped while busy.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        FLT_SEGNUM  = 2'd0,
        FLT_INVALID = 2'd1,
        FLT_LIMIT   = 2'd2,
        FLT_PERM    = 2'd3
    } flt_e;

    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_EX  = 2'd2,
        ACC_RSV = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } st_e;

endpackage

// File: rtl/seg_entry_unpack.sv
module seg_entry_unpack #(
    parameter int PA_W  = 16,
    parameter int LIM_W = 13,
    parameter int ENT_W = PA_W + LIM_W + 4
) (
    input  logic [ENT_W-1:0] word,
    output logic [PA_W-1:0]  base,
    output logic [LIM_W-1:0] limit,
    output logic             valid,
    output logic [2:0]       rights   // {exec, write, read}
);
    localparam int FLAG_LO = PA_W + LIM_W;

    assign base   = word[PA_W-1:0];
    assign limit  = word[FLAG_LO-1:PA_W];
    assign valid  = word[FLAG_LO];
    assign rights = word[FLAG_LO+3:FLAG_LO+1];
endmodule

// File: rtl/seg_rights_check.sv
module seg_rights_check
    import seg_xlate_pkg::*;
#(
    parameter int OFF_W = 12,
    parameter int LIM_W = OFF_W + 1
) (
    input  logic             valid,
    input  logic [LIM_W-1:0] limit,
    input  logic [2:0]       rights,
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       acc,
    output logic             ok,
    output flt_e             code
);
    logic allowed;

    always_comb begin
        unique case (acc)
            ACC_RD:  allowed = rights[0];
            ACC_WR:  allowed = rights[1];
            ACC_EX:  allowed = rights[2];
            default: allowed = 1'b0;
        endcase
    end

    // fixed precedence: valid bit, then limit, then rights
    always_comb begin
        ok   = 1'b0;
        code = FLT_PERM;
        if (!valid) begin
            code = FLT_INVALID;
        end else if (LIM_W'(off) >= limit) begin
            code = FLT_LIMIT;
        end else if (!allowed) begin
            code = FLT_PERM;
        end else begin
            ok = 1'b1;
        end
    end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W  = 4,
    parameter int OFF_W  = 12,
    parameter int PA_W   = 16,
    parameter int MEM_AW = 16,
    parameter int LIM_W  = OFF_W + 1,
    parameter int ENT_W  = PA_W + LIM_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [1:0]        req_acc,
    input  logic [MEM_AW-1:0] table_base,
    input  logic [SEG_W:0]    table_len,
    output logic              busy,
    output logic              mem_req,
    output logic [MEM_AW-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [ENT_W-1:0]  mem_rdata,
    output logic              done,
    output logic [PA_W-1:0]   phys_addr,
    output logic              fault,
    output logic [1:0]        fault_code
);
    localparam int SEGN_W = SEG_W + 1;

    typedef struct packed {
        st_e               st;
        logic [MEM_AW-1:0] addr;
        logic [OFF_W-1:0]  off;
        logic [1:0]        acc;
        logic              done;
        logic              fault;
        flt_e              code;
        logic [PA_W-1:0]   phys;
    } xl_state_t;

    xl_state_t r_q, r_d;

    logic [PA_W-1:0]  ent_base;
    logic [LIM_W-1:0] ent_limit;
    logic             ent_valid;
    logic [2:0]       ent_rights;
    logic             chk_ok;
    flt_e             chk_code;

    seg_entry_unpack #(.PA_W(PA_W), .LIM_W(LIM_W), .ENT_W(ENT_W)) u_unpack (
        .word   (mem_rdata),
        .base   (ent_base),
        .limit  (ent_limit),
        .valid  (ent_valid),
        .rights (ent_rights)
    );

    seg_rights_check #(.OFF_W(OFF_W), .LIM_W(LIM_W)) u_rights (
        .valid  (ent_valid),
        .limit  (ent_limit),
        .rights (ent_rights),
        .off    (r_q.off),
        .acc    (r_q.acc),
        .ok     (chk_ok),
        .code   (chk_code)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.fault = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (SEGN_W'(req_seg) >= table_len) begin
                        r_d.fault = 1'b1;
                        r_d.code  = FLT_SEGNUM;
                    end else begin
                        r_d.st   = ST_ISSUE;
                        r_d.addr = table_base + MEM_AW'(req_seg);
                        r_d.off  = req_off;
                        r_d.acc  = req_acc;
                    end
                end
            end
            ST_ISSUE: r_d.st = ST_WAIT;
            ST_WAIT: begin
                if (mem_rvalid) begin
                    r_d.st = ST_IDLE;
                    if (chk_ok) begin
                        r_d.done = 1'b1;
                        r_d.phys = ent_base + PA_W'(r_q.off);
                    end else begin
                        r_d.fault = 1'b1;
                        r_d.code  = chk_code;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy       = (r_q.st != ST_IDLE);
    assign mem_req    = (r_q.st == ST_ISSUE);
    assign mem_addr   = r_q.addr;
    assign done       = r_q.done;
    assign fault      = r_q.fault;
    assign fault_code = r_q.code;
    assign phys_addr  = r_q.phys;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       mem_req,
    input logic       done,
    input logic       fault,
    input logic [1:0] fault_code
);
    assert_one_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    assert_single_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    assert_segnum_no_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && fault_code == 2'd0) |-> !$past(busy));

    assert_done_after_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    assert_entry_fault_after_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && fault_code != 2'd0) |-> $past(busy));

    assert_result_ends_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |-> !busy);
endmodule

bind seg_xlate seg_xlate_chk u_chk (.*);

// File: tb/seg_xlate_tb_top.sv
module seg_xlate_tb_top;
    localparam int SEG_W = 4, OFF_W = 12, PA_W = 16, MEM_AW = 16;
    localparam int LIM_W = OFF_W + 1;
    localparam int ENT_W = PA_W + LIM_W + 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [SEG_W-1:0]  req_seg = '0;
    logic [OFF_W-1:0]  req_off = '0;
    logic [1:0]        req_acc = '0;
    logic [MEM_AW-1:0] table_base = 16'h0100;
    logic [SEG_W:0]    table_len = 5'd5;
    logic              busy, mem_req, done, fault;
    logic [MEM_AW-1:0] mem_addr;
    logic              mem_rvalid = 1'b0;
    logic [ENT_W-1:0]  mem_rdata = '0;
    logic [PA_W-1:0]   phys_addr;
    logic [1:0]        fault_code;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    seg_xlate dut_i (.*);

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // R4 layout: base | limit | valid | read | write | exec (low to high)
    function automatic logic [ENT_W-1:0] mk(input logic [15:0] b, input logic [12:0] l,
                                              input bit v, input bit rd, input bit wr, input bit ex);
        return {ex, wr, rd, v, l, b};
    endfunction

    task automatic xlate(input logic [3:0] seg, input logic [11:0] off, input logic [1:0] acc,
                         input logic [ENT_W-1:0] ent, input int lat, input bit fetch,
                         input bit exp_ok, input logic [1:0] exp_code, input logic [15:0] exp_phys,
                         input string tag, input bit poke);
        @(negedge clk);
        req_valid = 1'b1; req_seg = seg; req_off = off; req_acc = acc;
        @(negedge clk);
        req_valid = 1'b0;
        if (!fetch) begin
            chk(fault === 1'b1 && done === 1'b0, {tag, " fault pulse"}, fault, 1);
            chk(fault_code === exp_code, {tag, " code"}, fault_code, exp_code);
            chk(mem_req === 1'b0, {tag, " no fetch"}, mem_req, 0);
            @(negedge clk);
            chk(fault === 1'b0 && busy === 1'b0 && mem_req === 1'b0, {tag, " settle"}, fault, 0);
            return;
        end
        chk(mem_req === 1'b1, {tag, " R3 fetch"}, mem_req, 1);
        chk(mem_addr === table_base + 16'(seg), {tag, " R3 addr"}, mem_addr, table_base + 16'(seg));
        for (int i = 0; i < lat; i++) begin
            if (poke) begin
                req_valid = 1'b1; req_seg = 4'hF; req_off = '0; req_acc = 2'd0;
            end
            @(negedge clk);
            chk(mem_req === 1'b0 && done === 1'b0 && fault === 1'b0, {tag, " R9 wait quiet"}, {mem_req, done, fault}, 0);
        end
        req_valid = 1'b0;
        mem_rvalid = 1'b1; mem_rdata = ent;
        @(negedge clk);
        mem_rvalid = 1'b0;
        chk(done === exp_ok && fault === !exp_ok, {tag, " outcome"}, {done, fault}, {exp_ok, !exp_ok});
        if (exp_ok) chk(phys_addr === exp_phys, {tag, " R8 phys"}, phys_addr, exp_phys);
        else        chk(fault_code === exp_code, {tag, " code"}, fault_code, exp_code);
        @(negedge clk);
        chk(done === 1'b0 && fault === 1'b0 && busy === 1'b0, {tag, " R9 single pulse"}, {done, fault, busy}, 0);
    endtask

    task automatic t_reset;
        chk(busy === 0 && mem_req === 0 && done === 0 && fault === 0, "R1 reset", {busy, mem_req, done, fault}, 0);
    endtask

    task automatic t_segnum;
        table_len = 5'd5;
        xlate(4'd5, 12'h0, 2'd0, '0, 1, 0, 0, 2'd0, 0, "R2 seg=len", 0);
        xlate(4'd15, 12'h0, 2'd0, '0, 1, 0, 0, 2'd0, 0, "R2 seg max", 0);
        table_len = 5'd0;
        xlate(4'd0, 12'h0, 2'd0, '0, 1, 0, 0, 2'd0, 0, "R2 empty table", 0);
        table_len = 5'd16;
        xlate(4'd15, 12'h010, 2'd0, mk(16'h8000, 13'h100, 1, 1, 0, 0), 1, 1, 1, 0, 16'h8010, "R2 last legal", 0);
        table_len = 5'd5;
    endtask

    task automatic t_success;
        xlate(4'd0, 12'h004, 2'd0, mk(16'h2000, 13'h040, 1, 1, 0, 0), 1, 1, 1, 0, 16'h2004, "R8 R4 read", 0);
        xlate(4'd3, 12'h7FF, 2'd1, mk(16'h1234, 13'h1000, 1, 0, 1, 0), 3, 1, 1, 0, 16'h1A33, "R8 write", 0);
        xlate(4'd4, 12'h020, 2'd2, mk(16'hFFF0, 13'h100, 1, 0, 0, 1), 2, 1, 1, 0, 16'h0010, "R8 exec wrap", 0);
        table_base = 16'hFFFE;
        xlate(4'd3, 12'h001, 2'd0, mk(16'h0040, 13'h002, 1, 1, 1, 1), 1, 1, 1, 0, 16'h0041, "R3 addr wrap", 0);
        table_base = 16'h0100;
    endtask

    task automatic t_invalid;
        xlate(4'd1, 12'hFFF, 2'd3, mk(16'h3000, 13'h010, 0, 0, 0, 0), 1, 1, 0, 2'd1, 0, "R5 invalid first", 0);
        xlate(4'd2, 12'h000, 2'd0, mk(16'h3000, 13'h010, 0, 1, 1, 1), 1, 1, 0, 2'd1, 0, "R5 invalid", 0);
    endtask

    task automatic t_limit;
        xlate(4'd2, 12'h00F, 2'd0, mk(16'h4000, 13'h010, 1, 1, 0, 0), 1, 1, 1, 0, 16'h400F, "R6 limit-1", 0);
        xlate(4'd2, 12'h010, 2'd0, mk(16'h4000, 13'h010, 1, 1, 0, 0), 1, 1, 0, 2'd2, 0, "R6 at limit", 0);
        xlate(4'd2, 12'h020, 2'd1, mk(16'h4000, 13'h010, 1, 1, 0, 0), 1, 1, 0, 2'd2, 0, "R6 before perm", 0);
        xlate(4'd2, 12'h000, 2'd0, mk(16'h4000, 13'h000, 1, 1, 1, 1), 1, 1, 0, 2'd2, 0, "R6 zero limit", 0);
    endtask

    task automatic t_perm;
        xlate(4'd1, 12'h001, 2'd0, mk(16'h5000, 13'h100, 1, 0, 1, 1), 1, 1, 0, 2'd3, 0, "R7 read denied", 0);
        xlate(4'd1, 12'h001, 2'd1, mk(16'h5000, 13'h100, 1, 1, 0, 1), 1, 1, 0, 2'd3, 0, "R7 write denied", 0);
        xlate(4'd1, 12'h001, 2'd2, mk(16'h5000, 13'h100, 1, 1, 1, 0), 1, 1, 0, 2'd3, 0, "R7 exec denied", 0);
        xlate(4'd1, 12'h001, 2'd3, mk(16'h5000, 13'h100, 1, 1, 1, 1), 1, 1, 0, 2'd3, 0, "R7 reserved", 0);
    endtask

    task automatic t_busy_ignore;
        xlate(4'd3, 12'h008, 2'd0, mk(16'h6000, 13'h100, 1, 1, 0, 0), 4, 1, 1, 0, 16'h6008, "R9 busy ignore", 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_segnum();
        t_success();
        t_invalid();
        t_limit();
        t_perm();
        t_busy_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule